// File: doc/BRIEF.md
# Scheduled Output Arbiter for a Mesh Router Port

This block sits on one output port of a two-dimensional mesh wormhole router. Five input channels (north, south, east, west and the local tile) offer packets as streams of flits, each flit tagged with an end-of-packet marker. The block picks one input at a time and forwards its flits unchanged to the single output. Once the first flit of a packet has gone out, the whole packet follows from the same input before any other input is considered.

Two arbitration modes exist. While the sequencer is halted, a rotating-priority arbiter shares the output fairly. While it runs, a small table of slots decides the order. Each slot names one input and how many packets to take from it. The slots are visited in turn and the table repeats without end. A programmed input that has nothing to send stalls the output; no other input is served in its place. A simple write-only register port loads the table and its length, and starts or halts the sequencer.

Top module: `sched_out_mux`

## Requirements
- R1: Input codes are north=0, south=1, east=2, west=3, local=4. A flit passes from the selected input to the output in the same cycle: `out_valid`, `out_last` and `out_data` equal that input's values, and at most one `in_ready` bit is high. An `in_ready` bit is high only when `out_ready` is high and that input is valid and selected.
- R2: After the first flit of a packet is accepted, every accepted flit comes from the same input until a flit with its last marker set has been accepted.
- R3: While halted, at each packet boundary the grant goes to the first valid input, searched cyclically from the input after the one whose packet ended last. After reset the search starts at north. A valid input is never left waiting while the output is free.
- R4: While running, a packet is accepted only from the input named by the current slot. After that slot's packet count has completed, the next slot becomes current.
- R5: A slot count of 0 behaves as a count of 1.
- R6: After the last active slot completes, slot 0 becomes current again.
- R7: While running, if the programmed input is not valid at a packet boundary, `out_valid` stays low even when other inputs are valid.
- R8: Register writes (`cfg_we` high): addresses 0..15 load slot N with the input code in bits 10:8 and the packet count in bits 7:0. Address 16 loads the index of the last active slot from bits 3:0. Address 17 starts the sequencer when bit 0 is 1 and halts it when bit 0 is 0.
- R9: Writes to the slot table or the last-index register are ignored while the sequencer is running.
- R10: A start write, including one issued while already running, makes slot 0 current with its packet count cleared.
- R11: A halt returns arbitration to the rotating-priority arbiter from the next packet boundary on. A packet already in flight completes first.
- R12: After reset the sequencer is halted, `out_valid` is low and all `in_ready` bits are low while no input is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 5 | Flit valid per input (bit = input code) |
| in_last | input | 5 | Last flit of packet per input |
| in_data | input | 5*DATA_W | Flit payloads, input k at bits k*DATA_W upward |
| in_ready | output | 5 | Flit accepted from input |
| out_valid | output | 1 | Output flit valid |
| out_last | output | 1 | Output flit ends its packet |
| out_data | output | DATA_W | Output flit payload |
| out_ready | input | 1 | Downstream can accept a flit |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | CFG_W | Register write data |

## Verification
The assertions watch, on every cycle, that at most one input is granted, that a granted input is only released at an end-of-packet flit, that a running sequencer only opens packets from the programmed input and stalls otherwise, that the halted arbiter never idles with a request pending, and that slot wrap and restart both land on slot 0. The fairness order of the rotation, the actual packet counts per slot, the refusal of table writes while running, and the clearing of a half-used count on restart all depend on sequences of packets. Only the bench's directed scenarios show them, by comparing the recorded order of packet sources with an expected string.

// File: rtl/sched_mux_pkg.sv
package sched_mux_pkg;

  localparam int unsigned NUM_IN = 5;
  localparam int unsigned SRC_W  = 3;

  localparam logic [SRC_W-1:0] SRC_NORTH = 3'd0;
  localparam logic [SRC_W-1:0] SRC_SOUTH = 3'd1;
  localparam logic [SRC_W-1:0] SRC_EAST  = 3'd2;
  localparam logic [SRC_W-1:0] SRC_WEST  = 3'd3;
  localparam logic [SRC_W-1:0] SRC_LOCAL = 3'd4;

  // next input in the rotation, local wraps to north
  function automatic logic [SRC_W-1:0] src_after(logic [SRC_W-1:0] s);
    return (s >= SRC_LOCAL) ? SRC_NORTH : s + 3'd1;
  endfunction

  // first requesting input found when searching from 'start' upward, cyclically
  function automatic logic [SRC_W-1:0] rotate_pick(logic [NUM_IN-1:0] req,
                                                   logic [SRC_W-1:0]  start);
    logic [SRC_W-1:0] probe;
    logic [SRC_W-1:0] won;
    logic             seen;
    probe = start;
    won   = start;
    seen  = 1'b0;
    for (int k = 0; k < NUM_IN; k++) begin
      if (!seen && req[probe]) begin
        won  = probe;
        seen = 1'b1;
      end
      probe = src_after(probe);
    end
    return won;
  endfunction

endpackage

// File: rtl/sched_rr_arb.sv
module sched_rr_arb
  import sched_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req,
  input  logic              done,
  input  logic [SRC_W-1:0]  done_src,
  output logic [SRC_W-1:0]  pick
);

  logic [SRC_W-1:0] start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    start_q <= SRC_NORTH;
    else if (done) start_q <= src_after(done_src);
  end

  assign pick = rotate_pick(req, start_q);

endmodule

// File: rtl/sched_regs.sv
module sched_regs
  import sched_mux_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CFG_W-1:0]         cfg_wdata,
  input  logic [$clog2(DEPTH)-1:0] rd_slot,
  output logic [SRC_W-1:0]         rd_src,
  output logic [CNT_W-1:0]         rd_cnt,
  output logic [$clog2(DEPTH)-1:0] last_slot,
  output logic                     running,
  output logic                     start_cmd
);

  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DEPTH + 1);

  logic [SRC_W-1:0] slot_src [DEPTH];
  logic [CNT_W-1:0] slot_cnt [DEPTH];
  logic [IDX_W-1:0] last_q;
  logic             run_q;
  logic             table_we, last_we, ctrl_we;
  logic             unused_hi;

  assign table_we  = cfg_we && !run_q && (cfg_addr < A_LAST);
  assign last_we   = cfg_we && !run_q && (cfg_addr == A_LAST);
  assign ctrl_we   = cfg_we && (cfg_addr == A_CTRL);
  assign start_cmd = ctrl_we && cfg_wdata[0];
  assign unused_hi = ^cfg_wdata[CFG_W-1:CNT_W+SRC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        slot_src[k] <= SRC_NORTH;
        slot_cnt[k] <= '0;
      end
    end else if (table_we) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (cfg_addr == ADDR_W'(k)) begin
          slot_src[k] <= cfg_wdata[CNT_W +: SRC_W];
          slot_cnt[k] <= cfg_wdata[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (last_we) last_q <= cfg_wdata[IDX_W-1:0];
      if (ctrl_we) run_q  <= cfg_wdata[0];
    end
  end

  assign rd_src    = slot_src[rd_slot];
  assign rd_cnt    = slot_cnt[rd_slot];
  assign last_slot = last_q;
  assign running   = run_q;

endmodule

// File: rtl/sched_stepper.sv
module sched_stepper #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_cmd,
  input  logic                     pkt_counted,
  input  logic [CNT_W-1:0]         limit,
  input  logic [$clog2(DEPTH)-1:0] last_slot,
  output logic [$clog2(DEPTH)-1:0] slot,
  output logic                     slot_adv
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] slot_q;
  logic [CNT_W-1:0] sent_q;

  // a slot is finished when this packet brings the tally up to its limit;
  // a limit of zero is satisfied by the first packet
  function automatic logic quota_met(logic [CNT_W-1:0] sent, logic [CNT_W-1:0] lim);
    return ({1'b0, sent} + 1'b1) >= {1'b0, lim};
  endfunction

  function automatic logic [IDX_W-1:0] slot_after(logic [IDX_W-1:0] s, logic [IDX_W-1:0] last);
    return (s == last) ? '0 : s + 1'b1;
  endfunction

  assign slot_adv = pkt_counted && !start_cmd && quota_met(sent_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      sent_q <= '0;
    end else if (start_cmd) begin
      slot_q <= '0;
      sent_q <= '0;
    end else if (slot_adv) begin
      slot_q <= slot_after(slot_q, last_slot);
      sent_q <= '0;
    end else if (pkt_counted) begin
      sent_q <= sent_q + 1'b1;
    end
  end

  assign slot = slot_q;

endmodule

// File: rtl/sched_out_mux.sv
module sched_out_mux
  import sched_mux_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned ADDR_W = $clog2(DEPTH) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [4:0]               in_valid,
  input  logic [4:0]               in_last,
  input  logic [5*DATA_W-1:0]      in_data,
  output logic [4:0]               in_ready,
  output logic                     out_valid,
  output logic                     out_last,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     out_ready,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [CFG_W-1:0]         cfg_wdata
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  // named events shared with the checker
  logic [SRC_W-1:0]  ent_src;
  logic [CNT_W-1:0]  ent_cnt;
  logic [IDX_W-1:0]  last_slot, slot;
  logic              running, start_cmd, slot_adv;
  logic [SRC_W-1:0]  rr_src, sel_src, lock_src_q;
  logic              lock_q, quota_q;
  logic [NUM_IN-1:0] hit;
  logic [DATA_W-1:0] lane [NUM_IN];
  logic              flit_xfer, pkt_begin, pkt_end, pkt_counted;

  sched_regs #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .CFG_W (CFG_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .rd_slot  (slot),
    .rd_src   (ent_src),
    .rd_cnt   (ent_cnt),
    .last_slot(last_slot),
    .running  (running),
    .start_cmd(start_cmd)
  );

  sched_stepper #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
  ) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_cmd  (start_cmd),
    .pkt_counted(pkt_counted),
    .limit      (ent_cnt),
    .last_slot  (last_slot),
    .slot       (slot),
    .slot_adv   (slot_adv)
  );

  sched_rr_arb u_rr (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (in_valid),
    .done    (pkt_end),
    .done_src(sel_src),
    .pick    (rr_src)
  );

  // a held packet keeps its input; otherwise the active mode chooses
  assign sel_src = lock_q  ? lock_src_q :
                   running ? ent_src    : rr_src;

  // an input code outside 0..4 matches no lane, so the output stalls
  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    assign hit[g]  = (sel_src == SRC_W'(g));
    assign lane[g] = hit[g] ? in_data[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    out_data = '0;
    for (int k = 0; k < NUM_IN; k++) out_data = out_data | lane[k];
  end

  assign out_valid = |(in_valid & hit);
  assign out_last  = |(in_last & hit);
  assign in_ready  = in_valid & hit & {NUM_IN{out_ready}};

  assign flit_xfer   = out_valid && out_ready;
  assign pkt_begin   = flit_xfer && !lock_q;
  assign pkt_end     = flit_xfer && out_last;
  assign pkt_counted = pkt_end && running && !start_cmd && (lock_q ? quota_q : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      lock_src_q <= SRC_NORTH;
    end else if (pkt_end) begin
      lock_q     <= 1'b0;
    end else if (pkt_begin) begin
      lock_q     <= 1'b1;
      lock_src_q <= sel_src;
    end
  end

  // a multi-flit packet counts toward a slot only if it opened under the
  // sequencer and no start arrived while it was in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         quota_q <= 1'b0;
    else if (start_cmd) quota_q <= 1'b0;
    else if (pkt_begin) quota_q <= running;
  end

endmodule

// File: rtl/sched_mux_checker.sv
module sched_mux_checker
  import sched_mux_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] in_valid,
  input logic [NUM_IN-1:0] in_ready,
  input logic              out_valid,
  input logic              out_last,
  input logic              out_ready,
  input logic              lock_q,
  input logic [SRC_W-1:0]  sel_src,
  input logic [SRC_W-1:0]  ent_src,
  input logic              running,
  input logic              pkt_begin,
  input logic              flit_xfer,
  input logic [IDX_W-1:0]  slot,
  input logic [IDX_W-1:0]  last_slot,
  input logic              slot_adv,
  input logic              start_cmd
);

  logic prog_req;
  assign prog_req = |(in_valid & (NUM_IN'(1) << ent_src));

  p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  p_grant_needs_sink_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> out_ready);

  p_packet_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_xfer && !out_last) |=> (lock_q && sel_src == $past(sel_src)));

  p_no_idle_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !lock_q && (|in_valid)) |-> out_valid);

  p_prog_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pkt_begin) |-> (sel_src == ent_src));

  p_slot_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_adv && slot == last_slot) |=> (slot == '0));

  p_wait_programmed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !lock_q && !prog_req) |-> !out_valid);

  p_restart_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (slot == '0));

endmodule

bind sched_out_mux sched_mux_checker #(.IDX_W($clog2(DEPTH))) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_last (out_last),
  .out_ready(out_ready),
  .lock_q   (lock_q),
  .sel_src  (sel_src),
  .ent_src  (ent_src),
  .running  (running),
  .pkt_begin(pkt_begin),
  .flit_xfer(flit_xfer),
  .slot     (slot),
  .last_slot(last_slot),
  .slot_adv (slot_adv),
  .start_cmd(start_cmd)
);

// File: tb/test_sched_out_mux.sv
`timescale 1ns/100ps
module test_sched_out_mux;

  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    in_valid = '0, in_last = '0, in_ready;
  logic [5*DW-1:0] in_data = '0;
  logic          out_valid, out_last, out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;

  always #2.5 clk = ~clk;

  sched_out_mux i_sched_out_mux (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_last(out_last), .out_data(out_data), .out_ready(out_ready),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int total = 0, bad = 0, cyc = 0;
  int pk_left[5], plen[5], fidx[5], pk_no[5];
  int pkt_log[512];
  int pkt_n = 0, cur_src = 0;
  bit in_pkt = 0, bp_on = 0, seen_valid = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] flit_word(int p);
    return DW'((p << 16) | ((pk_no[p] & 255) << 8) | (fidx[p] & 255));
  endfunction

  // one clock: drive at the falling edge, observe 1 ns later, commit at the rising edge
  task automatic step_cfg(input bit we, input int addr, input int data);
    int gp;
    @(negedge clk);
    cfg_we = we; cfg_addr = AW'(addr); cfg_wdata = 16'(data);
    for (int p = 0; p < 5; p++) begin
      in_valid[p] = (pk_left[p] > 0);
      in_last[p]  = (fidx[p] == plen[p] - 1);
      in_data[p*DW +: DW] = flit_word(p);
    end
    out_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
    #1;
    seen_valid = out_valid;
    if ($countones(in_ready) > 1) chk(0, "R1 one grant", $countones(in_ready), 1);
    if (!out_ready && in_ready != 0) chk(0, "R1 ready without sink", int'(in_ready), 0);
    if (out_valid && out_ready) begin
      gp = -1;
      for (int p = 0; p < 5; p++) if (in_ready[p]) gp = p;
      if (gp < 0) chk(0, "R1 transfer with no ready", 0, 1);
      else begin
        if (out_data != flit_word(gp)) chk(0, "R1 data", int'(out_data), int'(flit_word(gp)));
        if (out_last != in_last[gp])   chk(0, "R1 last", out_last, in_last[gp]);
        if (!in_pkt) begin
          pkt_log[pkt_n] = gp; pkt_n++; cur_src = gp; in_pkt = 1;
        end else if (gp != cur_src) chk(0, "R2 packet interleaved", gp, cur_src);
        if (in_last[gp]) begin
          in_pkt = 0; fidx[gp] = 0; pk_left[gp]--; pk_no[gp]++;
        end else fidx[gp]++;
      end
    end
    cyc++;
    @(posedge clk);
    #0.5;
    cfg_we = 1'b0;
  endtask

  task automatic step(); step_cfg(0, 0, 0); endtask
  task automatic run(input int n); for (int i = 0; i < n; i++) step(); endtask
  task automatic wr(input int addr, input int data); step_cfg(1, addr, data); endtask
  task automatic load(input int p, input int n, input int len);
    pk_left[p] = n; plen[p] = len; fidx[p] = 0;
  endtask

  task automatic check_seq(input int base, input string s, input string req);
    chk(pkt_n == base + s.len(), {req, " packet count"}, pkt_n - base, s.len());
    for (int i = 0; i < s.len(); i++)
      if (base + i < pkt_n)
        chk(pkt_log[base+i] == int'(s[i]) - 48, {req, " packet source"}, pkt_log[base+i], int'(s[i]) - 48);
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 0, "R12 out_valid after reset", out_valid, 0);
    chk(in_ready == 0, "R12 in_ready after reset", int'(in_ready), 0);
  endtask

  task automatic t_round_robin();
    int b;
    b = pkt_n; bp_on = 1;
    for (int p = 0; p < 5; p++) load(p, 2, 2);
    run(60);
    check_seq(b, "0123401234", "R3 all five");
    bp_on = 0;
    b = pkt_n;
    load(1, 2, 3); load(4, 2, 3);
    run(30);
    check_seq(b, "1414", "R3 south/local");
  endtask

  task automatic t_program();
    int b;
    wr(0, (4 << 8) | 2);      // R8 slot 0: local x2
    wr(1, (3 << 8) | 1);      // slot 1: west x1
    wr(16, 1);
    wr(17, 1);
    b = pkt_n;
    load(4, 4, 1); load(3, 2, 1); load(0, 3, 2);
    run(40);
    check_seq(b, "443443", "R4 R6 programmed order");
    step();
    chk(seen_valid == 0, "R7 idle while programmed input empty", seen_valid, 0);
    chk(pk_left[0] == 3, "R7 north untouched", pk_left[0], 3);
    b = pkt_n;
    wr(17, 0);
    run(20);
    check_seq(b, "000", "R11 halt returns to rotation");
  endtask

  task automatic t_locked_table();
    int b;
    wr(0, (1 << 8) | 1);      // south x1
    wr(1, (2 << 8) | 0);      // east, count 0 acts as 1 (R5)
    wr(16, 1);
    wr(17, 1);
    wr(0, (0 << 8) | 5);      // R9 ignored while running
    wr(16, 0);                // R9 ignored while running
    b = pkt_n;
    load(1, 2, 2); load(2, 2, 2); load(0, 2, 2);
    run(40);
    check_seq(b, "1212", "R5 R9 table kept");
    chk(pk_left[0] == 2, "R9 north not served", pk_left[0], 2);
    b = pkt_n;
    wr(17, 0);
    run(20);
    check_seq(b, "00", "R11 drain after halt");
  endtask

  task automatic t_restart();
    int b;
    wr(0, (0 << 8) | 2);      // north x2
    wr(1, (2 << 8) | 2);      // east x2
    wr(16, 1);
    wr(17, 1);
    b = pkt_n;
    load(0, 3, 1);
    run(20);
    check_seq(b, "00", "R10 before restart");
    b = pkt_n;
    wr(17, 1);                // restart while waiting on east
    run(10);
    check_seq(b, "0", "R10 restart to slot 0");
    b = pkt_n;
    wr(17, 1);                // restart with slot 0 half used
    load(0, 2, 1); load(2, 1, 1);
    run(20);
    check_seq(b, "002", "R10 count cleared");
    wr(17, 0);
    run(4);
  endtask

  task automatic t_halt_mid_packet();
    int b;
    wr(0, (3 << 8) | 1);      // west x1
    wr(16, 0);
    wr(17, 1);
    b = pkt_n;
    load(3, 1, 4); load(0, 1, 1);
    run(2);
    wr(17, 0);                // halt in the middle of the west packet
    run(10);
    check_seq(b, "30", "R11 R2 packet completes first");
  endtask

  initial begin
    for (int p = 0; p < 5; p++) begin
      pk_left[p] = 0; plen[p] = 1; fidx[p] = 0; pk_no[p] = 0;
    end
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_round_robin();
    t_program();
    t_locked_table();
    t_restart();
    t_halt_mid_packet();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule